// File: doc/BRIEF.md
# DMA Channel Timeout Handler

This block is the control logic of one DMA channel, and it handles bus timeouts. The channel moves data one element at a time. Each element is a read handshake, which loads the channel buffer from the source, followed by a write handshake, which sends the buffer to the destination. Elements are grouped into frames. Two counters track progress: the number of elements done in the current frame, and the number of frames done.

A timeout can come from either of two sources: the external memory side or the peripheral bus side. When the channel is idle, a timeout clears the channel enable at once. When an element is in flight, the timeout is held pending until that element's write has been acknowledged, and the enable is cleared at that point. Both counters keep their values, so software can inspect them and then re-enable the channel to resume.

The timeout status bit is set only when the timeout interrupt enable is 1. The interrupt output is high while the status bit and the interrupt enable are both set. A read strobe on the status register clears the status bit.

The sequencer has three states:
- ST_IDLE: no request is raised.
- ST_READ: `rd_req` is high.
- ST_WRITE: `wr_req` is high.

The transitions are:
- T_START (ST_IDLE to ST_READ): the channel is enabled, the run is not finished and no timeout is taken.
- T_RD_DONE (ST_READ to ST_WRITE): `rd_ack` arrives.
- T_NEXT (ST_WRITE to ST_READ): `wr_ack` arrives while the channel stays enabled and more elements remain.
- T_STOP (ST_WRITE to ST_IDLE): `wr_ack` arrives together with a taken timeout, the last element of the run, or a software disable.

A timeout taken in ST_IDLE keeps the sequencer in ST_IDLE.

Top module: `dma_tout_chan`

## Requirements
- R1: An element is a read followed by a write.
  - `rd_req` stays high until `rd_ack`.
  - `rd_data` is captured on `rd_ack`.
  - `wr_req` rises in the cycle after `rd_ack` and drives the captured data on `wr_data`.
  - `rd_req` and `wr_req` are never high together.
  - If the channel stays enabled and more elements remain, `rd_req` is high again in the cycle after `wr_ack`.
- R2: After `ch_en` becomes 1 with the run unfinished and no timeout, `rd_req` rises one cycle later.
- R3: A timeout (either input high for one cycle) during an element does not cut the handshakes short. The element completes, and `ch_en` is 0 in the cycle after its `wr_ack`, with no further `rd_req`.
- R4: A timeout while the sequencer is idle and the channel is enabled clears `ch_en` at the next edge, and no read starts.
- R5: A taken timeout sets `stat_tout` only if `ie` is 1 at that moment. `irq` equals `stat_tout` AND `ie`.
- R6: A `stat_rd` strobe clears `stat_tout` at the next edge. If a timeout with `ie`=1 is taken in the same cycle, the status bit stays set.
- R7: An enable write of 1 in the same cycle that a timeout is taken is lost: `ch_en` stays 0.
- R8: Both counters keep their values while the channel is stopped by a timeout. A later enable write resumes from them.
- R9: Counting and run completion:
  - `elem_cnt` counts elements done in the current frame and wraps to 0 after `cfg_elems` elements, at which point `frm_cnt` increments.
  - When `frm_cnt` reaches `cfg_frames`, `ch_en` clears.
  - An enable write of 1 after completion restarts both counters from 0.
  - `cfg_elems` and `cfg_frames` must be at least 1.
- R10: `mem_tout` and `per_tout` have identical effect.
- R11: Writing 0 to the enable during an element lets that element finish, then the channel goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the channel enable |
| en_wdata | input | 1 | Enable value to write |
| ie_wr | input | 1 | Write strobe for the timeout interrupt enable |
| ie_wdata | input | 1 | Interrupt enable value to write |
| stat_rd | input | 1 | Status register read strobe (clears status) |
| mem_tout | input | 1 | Timeout from the external memory side |
| per_tout | input | 1 | Timeout from the peripheral bus side |
| cfg_elems | input | ELEM_W | Elements per frame |
| cfg_frames | input | FRM_W | Frames per run |
| rd_req | output | 1 | Source read request |
| rd_ack | input | 1 | Source read acknowledge |
| rd_data | input | DATA_W | Source read data |
| wr_req | output | 1 | Destination write request |
| wr_ack | input | 1 | Destination write acknowledge |
| wr_data | output | DATA_W | Buffered write data |
| ch_en | output | 1 | Channel enable bit |
| ie | output | 1 | Timeout interrupt enable bit |
| stat_tout | output | 1 | Timeout status bit |
| irq | output | 1 | Timeout interrupt request |
| busy | output | 1 | An element is in flight |
| elem_cnt | output | ELEM_W | Elements done in the current frame |
| frm_cnt | output | FRM_W | Frames done |

## Verification
The bench builds the block with DATA_W=16, ELEM_W=4 and FRM_W=3, and sets cfg_elems to 3 and cfg_frames to 2. With those settings, a full run of six elements is short enough to cover several cases in one pass: the element-counter wrap into the next frame, the stop at run completion and the restart. The same run also contains timeouts injected in the read phase, in the write-acknowledge cycle and while idle.

The timeout input stage is left unregistered (TOUT_SYNC=0). As a result, an idle-channel timeout acts at the very next edge, and that edge is where the bench samples.

// File: rtl/dma_tout_pkg.sv
package dma_tout_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dma_tout_merge.sv
module dma_tout_merge #(
    parameter int N_SRC     = 2,
    parameter bit TOUT_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    output logic             hit
);

    logic any_src;

    always_comb begin
        any_src = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            any_src = any_src | src[i];
        end
    end

    generate
        if (TOUT_SYNC) begin : g_sync
            logic hit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hit_q <= 1'b0;
                end else begin
                    hit_q <= any_src;
                end
            end
            assign hit = hit_q;
        end else begin : g_direct
            assign hit = any_src;
        end
    endgenerate

endmodule

// File: rtl/dma_tout_ctl.sv
module dma_tout_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic ie_wr,
    input  logic ie_wdata,
    input  logic stat_rd,
    input  logic tout_any,
    input  logic take,
    input  logic fin,
    output logic en,
    output logic ie,
    output logic stat,
    output logic irq,
    output logic tout_hit
);

    logic en_q;
    logic ie_q;
    logic stat_q;
    logic pend_q;

    // A timeout seen now or earlier and not yet acted upon
    assign tout_hit = pend_q | tout_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= tout_hit & ~take;
        end
    end

    // Enable: a taken timeout or run completion beats a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (take || fin) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ie_wr) begin
            ie_q <= ie_wdata;
        end
    end

    // Status: setting has priority over read-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (take && ie_q) begin
            stat_q <= 1'b1;
        end else if (stat_rd) begin
            stat_q <= 1'b0;
        end
    end

    assign en   = en_q;
    assign ie   = ie_q;
    assign stat = stat_q;
    assign irq  = stat_q & ie_q;

endmodule

// File: rtl/dma_tout_cnt.sv
module dma_tout_cnt #(
    parameter int ELEM_W = 8,
    parameter int FRM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_done,
    input  logic              restart,
    input  logic [ELEM_W-1:0] cfg_elems,
    input  logic [FRM_W-1:0]  cfg_frames,
    output logic [ELEM_W-1:0] elem_cnt,
    output logic [FRM_W-1:0]  frm_cnt,
    output logic              last_elem,
    output logic              run_done
);

    localparam logic [ELEM_W-1:0] ELEM_ONE = ELEM_W'(1);
    localparam logic [FRM_W-1:0]  FRM_ONE  = FRM_W'(1);

    logic [ELEM_W-1:0] elem_q;
    logic [FRM_W-1:0]  frm_q;
    logic              frame_end;

    assign frame_end = (elem_q == cfg_elems - ELEM_ONE);
    assign last_elem = frame_end && (frm_q == cfg_frames - FRM_ONE);
    assign run_done  = (frm_q == cfg_frames);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem_q <= '0;
            frm_q  <= '0;
        end else if (restart) begin
            elem_q <= '0;
            frm_q  <= '0;
        end else if (elem_done) begin
            if (frame_end) begin
                elem_q <= '0;
                frm_q  <= frm_q + FRM_ONE;
            end else begin
                elem_q <= elem_q + ELEM_ONE;
            end
        end
    end

    assign elem_cnt = elem_q;
    assign frm_cnt  = frm_q;

endmodule

// File: rtl/dma_tout_seq.sv
module dma_tout_seq
    import dma_tout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tout_hit,
    input  logic run_done,
    input  logic last_elem,
    input  logic rd_ack,
    input  logic wr_ack,
    output logic rd_req,
    output logic wr_req,
    output logic rd_fire,
    output logic elem_done,
    output logic take,
    output logic fin,
    output logic busy
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_IDLE;
                end else if (en && !run_done) begin
                    state_d = ST_READ;              // T_START
                end
            end
            ST_READ: begin
                if (rd_ack) begin
                    state_d = ST_WRITE;             // T_RD_DONE
                end
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    if (take || fin || !en) begin
                        state_d = ST_IDLE;          // T_STOP
                    end else begin
                        state_d = ST_READ;          // T_NEXT
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        rd_fire   = 1'b0;
        elem_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_READ: begin
                rd_req  = 1'b1;
                rd_fire = rd_ack;
            end
            ST_WRITE: begin
                wr_req    = 1'b1;
                elem_done = wr_ack;
            end
            default: begin
            end
        endcase
        busy = (state_q != ST_IDLE);
        take = tout_hit && (!busy || elem_done);
        fin  = elem_done && last_elem;
    end

endmodule

// File: rtl/dma_tout_chan.sv
module dma_tout_chan #(
    parameter int DATA_W    = 32,
    parameter int ELEM_W    = 8,
    parameter int FRM_W     = 8,
    parameter bit TOUT_SYNC = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    input  logic              stat_rd,
    input  logic              mem_tout,
    input  logic              per_tout,
    input  logic [ELEM_W-1:0] cfg_elems,
    input  logic [FRM_W-1:0]  cfg_frames,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [DATA_W-1:0] wr_data,
    output logic              ch_en,
    output logic              ie,
    output logic              stat_tout,
    output logic              irq,
    output logic              busy,
    output logic [ELEM_W-1:0] elem_cnt,
    output logic [FRM_W-1:0]  frm_cnt
);

    localparam int N_SRC = 2;

    logic              tout_any;
    logic              tout_hit;
    logic              take;
    logic              fin;
    logic              rd_fire;
    logic              elem_done;
    logic              last_elem;
    logic              run_done;
    logic              restart;
    logic [DATA_W-1:0] buf_q;

    dma_tout_merge #(
        .N_SRC     (N_SRC),
        .TOUT_SYNC (TOUT_SYNC)
    ) merge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .src   ({per_tout, mem_tout}),
        .hit   (tout_any)
    );

    dma_tout_ctl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .ie_wr    (ie_wr),
        .ie_wdata (ie_wdata),
        .stat_rd  (stat_rd),
        .tout_any (tout_any),
        .take     (take),
        .fin      (fin),
        .en       (ch_en),
        .ie       (ie),
        .stat     (stat_tout),
        .irq      (irq),
        .tout_hit (tout_hit)
    );

    dma_tout_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ch_en),
        .tout_hit  (tout_hit),
        .run_done  (run_done),
        .last_elem (last_elem),
        .rd_ack    (rd_ack),
        .wr_ack    (wr_ack),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_fire   (rd_fire),
        .elem_done (elem_done),
        .take      (take),
        .fin       (fin),
        .busy      (busy)
    );

    // A software enable write after a finished run starts a fresh run
    assign restart = en_wr && en_wdata && !take && run_done;

    dma_tout_cnt #(
        .ELEM_W (ELEM_W),
        .FRM_W  (FRM_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_done  (elem_done),
        .restart    (restart),
        .cfg_elems  (cfg_elems),
        .cfg_frames (cfg_frames),
        .elem_cnt   (elem_cnt),
        .frm_cnt    (frm_cnt),
        .last_elem  (last_elem),
        .run_done   (run_done)
    );

    // Channel buffer between the read and write phases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (rd_fire) begin
            buf_q <= rd_data;
        end
    end

    assign wr_data = buf_q;

endmodule

// File: rtl/dma_tout_chk.sv
module dma_tout_chk #(
    parameter int ELEM_W = 8,
    parameter int FRM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              wr_req,
    input logic              wr_ack,
    input logic              ch_en,
    input logic              ie,
    input logic              stat_tout,
    input logic              busy,
    input logic              tout_any,
    input logic              en_wr,
    input logic              en_wdata,
    input logic              stat_rd,
    input logic [ELEM_W-1:0] elem_cnt,
    input logic [FRM_W-1:0]  frm_cnt
);

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R1

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_req) |-> $past(rd_req && rd_ack)); // R1

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_ack) |=> rd_req); // R3

    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && !wr_ack) |=> wr_req); // R3

    AST_IDLE_TOUT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && tout_any) |=> (!ch_en && !rd_req)); // R4

    AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_tout) |-> $past(ie)); // R5

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !busy && !tout_any) |=> !stat_tout); // R6

    AST_TOUT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && tout_any && en_wr && en_wdata) |=> !ch_en); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !en_wr) |=> ($stable(elem_cnt) && $stable(frm_cnt))); // R8

endmodule

bind dma_tout_chan dma_tout_chk #(
    .ELEM_W (ELEM_W),
    .FRM_W  (FRM_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .wr_req    (wr_req),
    .wr_ack    (wr_ack),
    .ch_en     (ch_en),
    .ie        (ie),
    .stat_tout (stat_tout),
    .busy      (busy),
    .tout_any  (tout_any),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .stat_rd   (stat_rd),
    .elem_cnt  (elem_cnt),
    .frm_cnt   (frm_cnt)
);

// File: tb/dma_tout_chan_tb.sv
module dma_tout_chan_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int ELEM_W     = 4;
    localparam int FRM_W      = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_wr = 1'b0;
    logic              en_wdata = 1'b0;
    logic              ie_wr = 1'b0;
    logic              ie_wdata = 1'b0;
    logic              stat_rd = 1'b0;
    logic              mem_tout = 1'b0;
    logic              per_tout = 1'b0;
    logic [ELEM_W-1:0] cfg_elems = ELEM_W'(3);
    logic [FRM_W-1:0]  cfg_frames = FRM_W'(2);
    logic              rd_req;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              wr_req;
    logic              wr_ack = 1'b0;
    logic [DATA_W-1:0] wr_data;
    logic              ch_en;
    logic              ie;
    logic              stat_tout;
    logic              irq;
    logic              busy;
    logic [ELEM_W-1:0] elem_cnt;
    logic [FRM_W-1:0]  frm_cnt;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_tout_chan #(
        .DATA_W    (DATA_W),
        .ELEM_W    (ELEM_W),
        .FRM_W     (FRM_W),
        .TOUT_SYNC (1'b0)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .ie_wr      (ie_wr),
        .ie_wdata   (ie_wdata),
        .stat_rd    (stat_rd),
        .mem_tout   (mem_tout),
        .per_tout   (per_tout),
        .cfg_elems  (cfg_elems),
        .cfg_frames (cfg_frames),
        .rd_req     (rd_req),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .wr_req     (wr_req),
        .wr_ack     (wr_ack),
        .wr_data    (wr_data),
        .ch_en      (ch_en),
        .ie         (ie),
        .stat_tout  (stat_tout),
        .irq        (irq),
        .busy       (busy),
        .elem_cnt   (elem_cnt),
        .frm_cnt    (frm_cnt)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sw_en(input logic v);
        en_wr = 1'b1;
        en_wdata = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic sw_ie(input logic v);
        ie_wr = 1'b1;
        ie_wdata = v;
        step();
        ie_wr = 1'b0;
    endtask

    task automatic pulse_tout(input bit per);
        if (per) per_tout = 1'b1;
        else     mem_tout = 1'b1;
    endtask

    // Serve one element; optional timeout in the read phase or in the
    // write-acknowledge cycle, optional software disable during the read.
    task automatic serve(input logic [DATA_W-1:0] d, input int rd_wait,
                         input bit tout_rd, input bit tout_wr,
                         input bit per, input bit drop_en);
        int n = 0;
        while (!rd_req && n < 50) begin
            step();
            n++;
        end
        chk("R1 rd_req raised", 32'(rd_req), 32'd1);
        for (int i = 0; i < rd_wait; i++) begin
            if (tout_rd && i == 0) pulse_tout(per);
            step();
            mem_tout = 1'b0;
            per_tout = 1'b0;
            chk("R3 rd_req held", 32'(rd_req), 32'd1);
        end
        rd_ack = 1'b1;
        rd_data = d;
        if (tout_rd && rd_wait == 0) pulse_tout(per);
        if (drop_en) begin
            en_wr = 1'b1;
            en_wdata = 1'b0;
        end
        step();
        rd_ack = 1'b0;
        en_wr = 1'b0;
        mem_tout = 1'b0;
        per_tout = 1'b0;
        chk("R1 wr_req after rd_ack", 32'(wr_req), 32'd1);
        chk("R1 rd_req low in write", 32'(rd_req), 32'd0);
        chk("R1 wr_data", 32'(wr_data), 32'(d));
        wr_ack = 1'b1;
        if (tout_wr) pulse_tout(per);
        step();
        wr_ack = 1'b0;
        mem_tout = 1'b0;
        per_tout = 1'b0;
    endtask

    task automatic t_reset();
        chk("reset ch_en", 32'(ch_en), 32'd0);
        chk("reset rd_req", 32'(rd_req), 32'd0);
        chk("reset wr_req", 32'(wr_req), 32'd0);
        chk("reset stat", 32'(stat_tout), 32'd0);
        chk("reset irq", 32'(irq), 32'd0);
        chk("reset busy", 32'(busy), 32'd0);
        chk("reset elem_cnt", 32'(elem_cnt), 32'd0);
        chk("reset frm_cnt", 32'(frm_cnt), 32'd0);
    endtask

    task automatic t_start_and_element();
        sw_ie(1'b1);
        sw_en(1'b1);
        chk("R2 ch_en set", 32'(ch_en), 32'd1);
        chk("R2 rd_req not yet", 32'(rd_req), 32'd0);
        step();
        chk("R2 rd_req one cycle later", 32'(rd_req), 32'd1);
        serve(16'hA001, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 elem_cnt 1", 32'(elem_cnt), 32'd1);
        chk("R1 next read follows", 32'(rd_req), 32'd1);
        chk("R1 ch_en kept", 32'(ch_en), 32'd1);
    endtask

    task automatic t_tout_in_read();
        serve(16'hA002, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 ch_en cleared after element", 32'(ch_en), 32'd0);
        chk("R3 no further read", 32'(rd_req), 32'd0);
        chk("R3 elem counted", 32'(elem_cnt), 32'd2);
        chk("R5 stat set ie=1", 32'(stat_tout), 32'd1);
        chk("R5 irq high", 32'(irq), 32'd1);
        for (int i = 0; i < 3; i++) step();
        chk("R3 still no read", 32'(rd_req), 32'd0);
        chk("R8 elem_cnt held", 32'(elem_cnt), 32'd2);
        chk("R8 frm_cnt held", 32'(frm_cnt), 32'd0);
    endtask

    task automatic t_stat_read();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R6 stat cleared by read", 32'(stat_tout), 32'd0);
        chk("R6 irq low", 32'(irq), 32'd0);
    endtask

    task automatic t_resume();
        sw_en(1'b1);
        chk("R8 re-enabled", 32'(ch_en), 32'd1);
        serve(16'hA003, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 elem wrap", 32'(elem_cnt), 32'd0);
        chk("R9 frame incr", 32'(frm_cnt), 32'd1);
        chk("R8 resume continues", 32'(ch_en), 32'd1);
    endtask

    task automatic t_sw_disable();
        serve(16'hA004, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R11 ch_en 0", 32'(ch_en), 32'd0);
        chk("R11 busy 0 after element", 32'(busy), 32'd0);
        chk("R11 element counted", 32'(elem_cnt), 32'd1);
        chk("R11 no status", 32'(stat_tout), 32'd0);
        step();
        chk("R11 no new read", 32'(rd_req), 32'd0);
    endtask

    task automatic t_idle_tout_gated();
        sw_ie(1'b0);
        sw_en(1'b1);
        per_tout = 1'b1;
        step();
        per_tout = 1'b0;
        chk("R4 ch_en cleared at once", 32'(ch_en), 32'd0);
        chk("R4 no read started", 32'(rd_req), 32'd0);
        chk("R10 per_tout acts", 32'(busy), 32'd0);
        chk("R5 no status ie=0", 32'(stat_tout), 32'd0);
        chk("R5 no irq ie=0", 32'(irq), 32'd0);
        chk("R8 elem held", 32'(elem_cnt), 32'd1);
    endtask

    task automatic t_tout_wins();
        sw_ie(1'b1);
        en_wr = 1'b1;
        en_wdata = 1'b1;
        mem_tout = 1'b1;
        step();
        en_wr = 1'b0;
        mem_tout = 1'b0;
        chk("R7 timeout beats enable", 32'(ch_en), 32'd0);
        chk("R5 stat set", 32'(stat_tout), 32'd1);
        stat_rd = 1'b1;
        mem_tout = 1'b1;
        step();
        stat_rd = 1'b0;
        mem_tout = 1'b0;
        chk("R6 set beats clear", 32'(stat_tout), 32'd1);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R6 clear", 32'(stat_tout), 32'd0);
    endtask

    task automatic t_complete_restart();
        sw_en(1'b1);
        serve(16'hA005, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 elem 2", 32'(elem_cnt), 32'd2);
        serve(16'hA006, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 done ch_en 0", 32'(ch_en), 32'd0);
        chk("R9 done frm", 32'(frm_cnt), 32'd2);
        chk("R9 done elem", 32'(elem_cnt), 32'd0);
        step();
        step();
        chk("R9 no read after done", 32'(rd_req), 32'd0);
        sw_en(1'b1);
        chk("R9 restart ch_en", 32'(ch_en), 32'd1);
        chk("R9 restart frm", 32'(frm_cnt), 32'd0);
        serve(16'hA007, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 per_tout at ack stops", 32'(ch_en), 32'd0);
        chk("R3 elem counted", 32'(elem_cnt), 32'd1);
        chk("R10 stat set", 32'(stat_tout), 32'd1);
        sw_ie(1'b0);
        chk("R5 irq follows ie", 32'(irq), 32'd0);
        chk("R5 stat kept", 32'(stat_tout), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_start_and_element();
        t_tout_in_read();
        t_stat_read();
        t_resume();
        t_sw_disable();
        t_idle_tout_gated();
        t_tout_wins();
        t_complete_restart();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule